// File: doc/BRIEF.md
# EPROM Pulse-and-Verify Programming Sequencer

This block sits on the programmer side of a parallel UV-erasable EPROM and writes a range of bytes into a blank device. It steps an address across the range. It presents the source byte for that address, gives a fixed-width program pulse, and then reads the cell back in verify mode. A byte that matches moves the walk on to the next address. A byte that does not match gets another pulse. Once a byte has taken its full allowance of pulses and still reads wrong, the run stops and the device is rejected.

When the last byte is in, the sequencer drops the programming supplies. It then re-reads the whole range against the source, first at the low operating supply and then at the high one. Any mismatch fails the device. The run reports its result with a one-cycle done strobe, a pass flag and the address that failed. The source bytes come from a byte-wide lookup port that the sequencer addresses. The supply switches themselves are outside the block: it drives only the two select outputs.

All timing is written in nanoseconds and turned into clock ticks through the `CLK_NS` parameter. The setup time, pulse width, hold time, read-valid delay and bus-float delay are all parameters.

Top module: `eprom_burn_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0. `rom_ce_n`, `rom_oe_n` and `rom_pgm_n` are 1. `prog_supply_on` is 0 and `rom_dout_en` is 0.
- R2: Each program pulse holds `rom_pgm_n` low for round(`PULSE_NS`/`CLK_NS`) ticks. This lies within `PULSE_NS` ± `PULSE_TOL_NS` (95 to 105 µs by default).
- R3: While `rom_pgm_n` is low, the following all hold: `rom_ce_n` = 0, `rom_oe_n` = 1, `prog_supply_on` = 1 and `rom_dout_en` = 1. Address, data and controls are unchanged for at least `SETUP_NS` before the falling edge. Data stays driven and unchanged for at least `HOLD_NS` after the rising edge.
- R4: After every pulse the byte is read back with `rom_pgm_n` = 1 and `rom_oe_n` = 0. Pulsing of an address stops at the first matching read, so a byte that needs k pulses (k ≤ `MAX_PULSES`) receives exactly k.
- R5: If a byte still mismatches after `MAX_PULSES` pulses, the run ends with `pass` = 0 and `fail_addr` = that address. No later address receives a pulse and no final re-read takes place.
- R6: `rom_dout_en` is never 1 while `rom_oe_n` is 0. After `rom_oe_n` rises, `rom_dout_en` stays 0 for at least `FLOAT_NS`.
- R7: After the last address verifies, `prog_supply_on` goes to 0. Every address in the range is then read exactly once with `verify_corner_hi` = 0, and after that exactly once with `verify_corner_hi` = 1. `verify_corner_hi` is 1 only while `prog_supply_on` is 0.
- R8: A final-read mismatch at either corner ends the run with `pass` = 0 and `fail_addr` = that address. A mismatch at the low corner ends the run before any high-corner read.
- R9: `done` is a single-cycle pulse with `busy` = 0 in that cycle. `pass` is 1 only when every byte programmed and both corner passes matched. `pass` and `fail_addr` hold until the next accepted start.
- R10: A `start` while `busy` is 1 is ignored. The range being written does not change, and no pulse lands outside it.
- R11: A range whose first and last address are equal is programmed and verified like any other range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when idle) |
| first_addr | input | ADDR_W | First address of the range |
| last_addr | input | ADDR_W | Last address of the range |
| src_addr | output | ADDR_W | Address into the source byte store |
| src_data | input | DATA_W | Source byte for `src_addr` |
| rom_addr | output | ADDR_W | EPROM address lines |
| rom_dout | output | DATA_W | Byte driven onto the EPROM data bus |
| rom_dout_en | output | 1 | Data bus driver enable |
| rom_din | input | DATA_W | Byte read from the EPROM data bus |
| rom_ce_n | output | 1 | EPROM chip enable, active low |
| rom_oe_n | output | 1 | EPROM output enable, active low |
| rom_pgm_n | output | 1 | EPROM program strobe, active low |
| prog_supply_on | output | 1 | 1 selects programming supply levels |
| verify_corner_hi | output | 1 | Final-read supply corner: 0 low, 1 high |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Result of the last run |
| fail_addr | output | ADDR_W | Address that failed in the last run |

## Verification
The assertions assume three things about the inputs. `src_data` is a pure function of `src_addr`. `rom_din` is compared only at the end of a read window. `first_addr` is not above `last_addr`. The pulse-width and bus-timing checks also assume that nothing outside the block forces the control pins. The bench meets these assumptions in several ways: its source store is a fixed table read combinationally, and its EPROM model drives read data only when chip and output enable are both low. Every range it launches is ascending. The only stimulus it changes during a run is a stray `start`, which the design must ignore.

// File: rtl/eprom_burn_pkg.sv
package eprom_burn_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RAMP,
        S_PSET,
        S_PULSE,
        S_PHOLD,
        S_VOE,
        S_VFLT,
        S_FRAMP,
        S_FOE,
        S_FFLT,
        S_END
    } burn_state_t;

    typedef enum logic [1:0] {
        W_HOLD,
        W_REWIND,
        W_NEXT,
        W_BUMP
    } walk_op_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic pgm_n;
        logic prog_on;
        logic drive;
    } pin_ctrl_t;

    function automatic int unsigned ticks_ceil(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned ticks_round(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns / 2) / clk_ns;
    endfunction

    // Pin levels seen by the EPROM in each sequencer state.
    function automatic pin_ctrl_t pins_for(input burn_state_t s);
        pin_ctrl_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, pgm_n: 1'b1, prog_on: 1'b0, drive: 1'b0};
        case (s)
            S_RAMP:  p.prog_on = 1'b1;
            S_PSET:  begin p.ce_n = 1'b0; p.prog_on = 1'b1; p.drive = 1'b1; end
            S_PULSE: begin p.ce_n = 1'b0; p.pgm_n = 1'b0; p.prog_on = 1'b1; p.drive = 1'b1; end
            S_PHOLD: begin p.ce_n = 1'b0; p.prog_on = 1'b1; p.drive = 1'b1; end
            S_VOE:   begin p.ce_n = 1'b0; p.oe_n = 1'b0; p.prog_on = 1'b1; end
            S_VFLT:  begin p.ce_n = 1'b0; p.prog_on = 1'b1; end
            S_FOE:   begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
            S_FFLT:  p.ce_n = 1'b0;
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/burn_timer.sv
module burn_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // Counter only moves down between loads.
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0) || $past(load));

endmodule

// File: rtl/burn_walker.sv
module burn_walker
    import eprom_burn_pkg::*;
#(
    parameter int unsigned ADDR_W     = 13,
    parameter int unsigned MAX_PULSES = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              hold_range,
    input  logic [ADDR_W-1:0] first_in,
    input  logic [ADDR_W-1:0] last_in,
    input  walk_op_t          op,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last,
    output logic              at_limit
);
    localparam int unsigned TRY_W = $clog2(MAX_PULSES + 1);
    localparam logic [TRY_W-1:0] TRY_MAX = TRY_W'(MAX_PULSES);

    logic [ADDR_W-1:0] lo_q, hi_q;
    logic [TRY_W-1:0]  tries;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q  <= '0;
            hi_q  <= '0;
            addr  <= '0;
            tries <= '0;
        end else if (load) begin
            lo_q  <= first_in;
            hi_q  <= last_in;
            addr  <= first_in;
            tries <= '0;
        end else begin
            case (op)
                W_REWIND: begin addr <= lo_q;        tries <= '0; end
                W_NEXT:   begin addr <= addr + 1'b1; tries <= '0; end
                W_BUMP:   tries <= tries + 1'b1;
                default:  ;
            endcase
        end
    end

    assign at_last  = (addr == hi_q);
    assign at_limit = (tries == TRY_MAX);

    // R5
    retry_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tries <= TRY_MAX);

    // R10
    range_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hold_range |=> (!hold_range || ($stable(lo_q) && $stable(hi_q))));

endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq
    import eprom_burn_pkg::*;
#(
    parameter int unsigned ADDR_W       = 13,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned CLK_NS       = 20,
    parameter int unsigned MAX_PULSES   = 10,
    parameter int unsigned PULSE_NS     = 100000,
    parameter int unsigned PULSE_TOL_NS = 5000,
    parameter int unsigned SETUP_NS     = 2000,
    parameter int unsigned HOLD_NS      = 2000,
    parameter int unsigned VALID_NS     = 100,
    parameter int unsigned FLOAT_NS     = 130
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic [DATA_W-1:0] rom_dout,
    output logic              rom_dout_en,
    input  logic [DATA_W-1:0] rom_din,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              rom_pgm_n,
    output logic              prog_supply_on,
    output logic              verify_corner_hi,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int unsigned SETUP_CYC = ticks_ceil(SETUP_NS, CLK_NS) + 1;
    localparam int unsigned HOLD_CYC  = ticks_ceil(HOLD_NS, CLK_NS) + 1;
    localparam int unsigned VALID_CYC = ticks_ceil(VALID_NS, CLK_NS) + 1;
    localparam int unsigned FLOAT_CYC = ticks_ceil(FLOAT_NS, CLK_NS) + 1;
    localparam int unsigned PULSE_CYC = ticks_round(PULSE_NS, CLK_NS);
    localparam int unsigned PW_MIN    = ticks_ceil(PULSE_NS - PULSE_TOL_NS, CLK_NS);
    localparam int unsigned PW_MAX    = (PULSE_NS + PULSE_TOL_NS) / CLK_NS;
    localparam int unsigned TMR_W     = $clog2(PULSE_CYC + SETUP_CYC + HOLD_CYC + VALID_CYC + FLOAT_CYC + 1);
    localparam int unsigned PW_W      = $clog2(PW_MAX + 2);

    localparam logic [TMR_W-1:0] T_SETUP = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] T_PULSE = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] T_HOLD  = TMR_W'(HOLD_CYC - 1);
    localparam logic [TMR_W-1:0] T_VALID = TMR_W'(VALID_CYC - 1);
    localparam logic [TMR_W-1:0] T_FLOAT = TMR_W'(FLOAT_CYC - 1);

    burn_state_t       state, nxt;
    walk_op_t          wop;
    logic              tload, tz;
    logic [TMR_W-1:0]  tval;
    logic              accept, match_q, corner_q, pass_q;
    logic              go_fail, go_pass, corner_up;
    logic [ADDR_W-1:0] addr, fail_q;
    logic              at_last, at_limit;
    pin_ctrl_t         pins;

    assign accept = start && (state == S_IDLE);

    burn_timer #(.W(TMR_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tload),
        .val  (tval),
        .zero (tz)
    );

    burn_walker #(.ADDR_W(ADDR_W), .MAX_PULSES(MAX_PULSES)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .hold_range (busy),
        .first_in   (first_addr),
        .last_in    (last_addr),
        .op         (wop),
        .addr       (addr),
        .at_last    (at_last),
        .at_limit   (at_limit)
    );

    always_comb begin
        nxt       = state;
        wop       = W_HOLD;
        tload     = 1'b0;
        tval      = '0;
        go_fail   = 1'b0;
        go_pass   = 1'b0;
        corner_up = 1'b0;
        case (state)
            S_IDLE:  if (start) begin nxt = S_RAMP; tload = 1'b1; tval = T_SETUP; end
            S_RAMP:  if (tz) begin nxt = S_PSET; tload = 1'b1; tval = T_SETUP; end
            S_PSET:  if (tz) begin nxt = S_PULSE; tload = 1'b1; tval = T_PULSE; wop = W_BUMP; end
            S_PULSE: if (tz) begin nxt = S_PHOLD; tload = 1'b1; tval = T_HOLD; end
            S_PHOLD: if (tz) begin nxt = S_VOE; tload = 1'b1; tval = T_VALID; end
            S_VOE:   if (tz) begin nxt = S_VFLT; tload = 1'b1; tval = T_FLOAT; end
            S_VFLT: if (tz) begin
                tload = 1'b1;
                tval  = T_SETUP;
                if (match_q) begin
                    if (at_last) begin nxt = S_FRAMP; wop = W_REWIND; end
                    else begin nxt = S_PSET; wop = W_NEXT; end
                end else if (at_limit) begin
                    nxt = S_END; go_fail = 1'b1;
                end else begin
                    nxt = S_PSET;
                end
            end
            S_FRAMP: if (tz) begin nxt = S_FOE; tload = 1'b1; tval = T_VALID; end
            S_FOE:   if (tz) begin nxt = S_FFLT; tload = 1'b1; tval = T_FLOAT; end
            S_FFLT: if (tz) begin
                if (!match_q) begin
                    nxt = S_END; go_fail = 1'b1;
                end else if (!at_last) begin
                    nxt = S_FOE; wop = W_NEXT; tload = 1'b1; tval = T_VALID;
                end else if (!corner_q) begin
                    nxt = S_FRAMP; wop = W_REWIND; tload = 1'b1; tval = T_SETUP; corner_up = 1'b1;
                end else begin
                    nxt = S_END; go_pass = 1'b1;
                end
            end
            S_END:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            match_q  <= 1'b0;
            corner_q <= 1'b0;
            pass_q   <= 1'b0;
            fail_q   <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                corner_q <= 1'b0;
                pass_q   <= 1'b0;
            end
            if ((state == S_VOE || state == S_FOE) && tz)
                match_q <= (rom_din == src_data);
            if (corner_up)
                corner_q <= 1'b1;
            if (go_fail)
                fail_q <= addr;
            if (go_pass)
                pass_q <= 1'b1;
        end
    end

    assign pins             = pins_for(state);
    assign rom_ce_n         = pins.ce_n;
    assign rom_oe_n         = pins.oe_n;
    assign rom_pgm_n        = pins.pgm_n;
    assign prog_supply_on   = pins.prog_on;
    assign rom_dout_en      = pins.drive;
    assign rom_addr         = addr;
    assign src_addr         = addr;
    assign rom_dout         = src_data;
    assign verify_corner_hi = corner_q;
    assign busy             = (state != S_IDLE) && (state != S_END);
    assign done             = (state == S_END);
    assign pass             = pass_q;
    assign fail_addr        = fail_q;

    logic [PW_W-1:0] pw_cnt;
    always_ff @(posedge clk) begin
        if (rst || rom_pgm_n)
            pw_cnt <= '0;
        else
            pw_cnt <= pw_cnt + 1'b1;
    end

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rom_pgm_n) |-> (pw_cnt >= PW_W'(PW_MIN) && pw_cnt <= PW_W'(PW_MAX)));

    // R3
    pulse_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        !rom_pgm_n |-> (!rom_ce_n && rom_oe_n && prog_supply_on && rom_dout_en));

    // R6
    bus_clash_chk: assert property (@(posedge clk) disable iff (rst)
        !(rom_dout_en && !rom_oe_n));

    // R7
    corner_supply_chk: assert property (@(posedge clk) disable iff (rst)
        verify_corner_hi |-> !prog_supply_on);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !$past(done)));

endmodule

// File: tb/eprom_burn_seq_test.sv
`timescale 1ns/1ps
module eprom_burn_seq_test;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [AW-1:0] first_addr = '0, last_addr = '0;
    logic [AW-1:0] src_addr, rom_addr, fail_addr;
    logic [7:0] src_data, rom_dout, rom_din;
    logic rom_dout_en, rom_ce_n, rom_oe_n, rom_pgm_n, prog_on, corner_hi, busy, done, pass;

    always #10 clk = ~clk;

    eprom_burn_seq #(.ADDR_W(AW), .DATA_W(8), .CLK_NS(1000)) uut (
        .clk(clk), .rst(rst), .start(start), .first_addr(first_addr), .last_addr(last_addr),
        .src_addr(src_addr), .src_data(src_data), .rom_addr(rom_addr), .rom_dout(rom_dout),
        .rom_dout_en(rom_dout_en), .rom_din(rom_din), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .rom_pgm_n(rom_pgm_n), .prog_supply_on(prog_on), .verify_corner_hi(corner_hi),
        .busy(busy), .done(done), .pass(pass), .fail_addr(fail_addr)
    );

    int checks = 0, failures = 0;
    logic [7:0] srcmem [DEPTH];
    logic [7:0] mem [DEPTH];
    logic [7:0] weak_lo [DEPTH];
    logic [7:0] weak_hi [DEPTH];
    int need [DEPTH];
    int pcount [DEPTH];
    int rdlo [DEPTH];
    int rdhi [DEPTH];
    int proto_err = 0, pw_min = 1 << 30, pw_max = 0, done_cnt = 0;

    assign src_data = srcmem[src_addr];

    always_comb begin
        rom_din = 8'hFF;
        if (!rom_ce_n && !rom_oe_n) begin
            rom_din = mem[rom_addr];
            if (!prog_on)
                rom_din = rom_din ^ (corner_hi ? weak_hi[rom_addr] : weak_lo[rom_addr]);
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            srcmem[i] = 8'(i * 37 + 8'h5A) & 8'hF7;
            mem[i] = 8'hFF; weak_lo[i] = 8'h00; weak_hi[i] = 8'h00;
            need[i] = 1; pcount[i] = 0; rdlo[i] = 0; rdhi[i] = 0;
        end
    end

    // EPROM model and pin-timing monitor, sampled on the falling edge
    logic pgm_p = 1'b1, oe_p = 1'b1, den_p = 1'b0, ce_p = 1'b1, prog_p = 1'b0, pulsed = 1'b0;
    logic [AW-1:0] addr_p = '0;
    logic [7:0] dout_p = '0, pdata = '0;
    int stab = 0, hold = 0, flt = 100, lowcnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rom_dout_en && !rom_oe_n) proto_err++;
            if (!rom_pgm_n && pgm_p) begin
                if (stab < 2 || rom_ce_n || !rom_oe_n || !prog_on || !rom_dout_en) proto_err++;
                pdata = rom_dout; lowcnt = 0;
            end
            if (!rom_pgm_n) lowcnt++;
            if (rom_pgm_n && !pgm_p) begin
                if (lowcnt < pw_min) pw_min = lowcnt;
                if (lowcnt > pw_max) pw_max = lowcnt;
                pcount[rom_addr]++;
                if (pcount[rom_addr] == need[rom_addr]) mem[rom_addr] = mem[rom_addr] & pdata;
                hold = 0; pulsed = 1'b1;
            end else hold++;
            if (pulsed && den_p && (!rom_dout_en || rom_dout != dout_p) && hold < 3) proto_err++;
            if (rom_dout_en && !den_p && flt < 1) proto_err++;
            if (rom_oe_n && !oe_p) flt = 0; else flt++;
            if (!rom_oe_n && oe_p && !prog_on && !rom_ce_n) begin
                if (corner_hi) rdhi[rom_addr]++; else rdlo[rom_addr]++;
            end
            if (rom_addr != addr_p || rom_dout != dout_p || rom_dout_en != den_p ||
                rom_ce_n != ce_p || rom_oe_n != oe_p || prog_on != prog_p) stab = 0;
            else stab++;
            if (done) done_cnt++;
        end
        pgm_p = rom_pgm_n; oe_p = rom_oe_n; den_p = rom_dout_en; ce_p = rom_ce_n;
        prog_p = prog_on; addr_p = rom_addr; dout_p = rom_dout;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic launch(input int lo, input int hi);
        @(negedge clk);
        first_addr = AW'(lo); last_addr = AW'(hi); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    logic res_pass;
    int res_fail;
    task automatic wait_done();
        int n = 0;
        while (!done && n < 60000) begin @(negedge clk); n++; end
        check(done, "R9 run finished", n, 60000);
        check(!busy, "R9 busy low with done", busy, 0);
        res_pass = pass; res_fail = fail_addr;
        @(negedge clk);
        check(!done && pass == res_pass, "R9 done one cycle, pass held", done, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && rom_ce_n && rom_oe_n && rom_pgm_n && !prog_on && !rom_dout_en,
              "R1 reset pins", {busy, done, rom_ce_n, rom_oe_n, rom_pgm_n, prog_on, rom_dout_en}, 7'b0011100);
    endtask

    task automatic t_program_range();
        need[3] = 1; need[4] = 3; need[5] = 2; need[6] = 10;
        launch(3, 6);
        wait_done();
        check(res_pass, "R9 pass after clean run", res_pass, 1);
        for (int a = 3; a <= 6; a++) begin
            check(pcount[a] == need[a], "R4 pulses equal needed", pcount[a], need[a]);
            check(mem[a] == srcmem[a], "R4 cell content", mem[a], srcmem[a]);
            check(rdlo[a] == 1 && rdhi[a] == 1, "R7 one read per corner", rdlo[a] * 10 + rdhi[a], 11);
        end
        check(pcount[2] == 0 && pcount[7] == 0, "R4 outside range untouched", pcount[2] + pcount[7], 0);
        check(pw_min >= 95 && pw_max <= 105 && pw_min == 100, "R2 pulse width ticks", pw_min, 100);
        check(proto_err == 0, "R3 R6 setup hold float", proto_err, 0);
    endtask

    task automatic t_retry_limit();
        need[11] = 11;
        launch(10, 12);
        wait_done();
        check(!res_pass && res_fail == 11, "R5 fail address", res_fail, 11);
        check(pcount[11] == 10, "R5 pulse cap", pcount[11], 10);
        check(pcount[12] == 0, "R5 later address untouched", pcount[12], 0);
        check(rdlo[10] == 0 && rdhi[10] == 0, "R5 no final reads", rdlo[10] + rdhi[10], 0);
    endtask

    task automatic t_weak_lo();
        weak_lo[21] = 8'h04;
        launch(20, 22);
        wait_done();
        check(!res_pass && res_fail == 21, "R8 low corner fail address", res_fail, 21);
        check(rdlo[20] == 1 && rdlo[21] == 1 && rdlo[22] == 0, "R8 low pass stops", rdlo[22], 0);
        check(rdhi[20] + rdhi[21] + rdhi[22] == 0, "R8 no high corner reads", rdhi[20] + rdhi[21] + rdhi[22], 0);
    endtask

    task automatic t_weak_hi();
        weak_hi[32] = 8'h80;
        launch(30, 32);
        wait_done();
        check(!res_pass && res_fail == 32, "R8 high corner fail address", res_fail, 32);
        check(rdlo[30] == 1 && rdlo[31] == 1 && rdlo[32] == 1, "R7 low corner full", rdlo[32], 1);
        check(rdhi[32] == 1, "R7 high corner reached", rdhi[32], 1);
    endtask

    task automatic t_busy_start();
        int d0;
        d0 = done_cnt;
        launch(40, 41);
        repeat (50) @(negedge clk);
        first_addr = 6'd50; last_addr = 6'd50; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R10 still busy", busy, 1);
        wait_done();
        check(res_pass && pcount[50] == 0, "R10 stray start ignored", pcount[50], 0);
        check(pcount[40] == 1 && pcount[41] == 1, "R10 original range done", pcount[41], 1);
        check(done_cnt - d0 == 1, "R9 one done strobe", done_cnt - d0, 1);
    endtask

    task automatic t_single();
        need[60] = 2;
        launch(60, 60);
        wait_done();
        check(res_pass, "R11 single address pass", res_pass, 1);
        check(pcount[60] == 2 && mem[60] == srcmem[60], "R11 single address programmed", pcount[60], 2);
        check(rdlo[60] == 1 && rdhi[60] == 1, "R11 single address reads", rdlo[60] + rdhi[60], 2);
        check(proto_err == 0, "R3 R6 timing over all runs", proto_err, 0);
    endtask

    initial begin
        #(20 * 190000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_program_range();
        t_retry_limit();
        t_weak_lo();
        t_weak_hi();
        t_busy_start();
        t_single();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule